// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a four-wire serial slave. A host uses it to reach a small bank of 4-bit control registers. The host has four signals: an active-low enable, a serial clock, a data input and a data output whose driver can be switched off. Every transaction is eight serial-clock periods long. The first four bits form a header: one direction bit, then a 3-bit register address. The last four bits are the data nibble. On a write the host sends the nibble. On a read the slave returns it.

The serial pins are not used as clocks. Each pin is synchronised into the system clock domain, and the serial-clock edges are found by comparing successive samples. The register values leave the block on dedicated outputs, so neighbouring logic can use them:

- line mode and channel
- detect timing
- function mode
- receive gain and detect level
- transmit attenuation
- tone code

Address 6 does not hold a stored value. It returns a 4-bit received-digit code that arrives from outside the block. The data-out driver is modelled as a data bit plus an output-enable bit, and the pad ring builds the tri-state from the two.

Top module: `sctl_regs`

## Requirements
- R1: The first bit a rising serial-clock edge captures after the enable falls is the direction bit: 1 means read and 0 means write. The next three rising edges capture the address, MSB first.
- R2: In a write, the following four rising edges capture the nibble, MSB first. The addressed register takes the nibble only at the fourth data bit.
- R3: In a read, `sdo_oe_o` goes high at the first falling serial-clock edge after the address. That edge drives the register MSB on `sdo_o`, and each of the next three falling edges drives the next lower bit.
- R4: `sdo_oe_o` is low at all other times: during the header, for the whole of a write, and after the falling edge that follows the last read bit.
- R5: Raising `sen_ni` abandons the transaction. `sdo_oe_o` goes low, and a write cut short leaves its register unchanged.
- R6: Serial-clock and data-in activity while `sen_ni` is high has no effect on the registers or on how the next frame is decoded.
- R7: Address 6 reads back `rx_digit_i`. Writes to address 6 change nothing.
- R8: After reset the stored values are: address 0 = 0010, address 1 = 0000, address 2 = 0000, address 3 = 0000, address 4 = 0000, address 5 = 1111.
- R9: Bit 0 of address 0 is not stored. It always reads and exports as 0.
- R10: Address 7 holds nothing. It reads as 0000, and writes to it change nothing.
- R11: Each of the outputs `line_mode_o`, `det_time_o`, `func_sel_o`, `rx_gain_o`, `tx_atten_o` and `tone_sel_o` shows the current value of its register, at addresses 0 to 5 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sen_ni | input | 1 | Serial enable, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial read data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |
| rx_digit_i | input | 4 | Received-digit code returned at address 6 |
| line_mode_o | output | 4 | Register 0 (bit 0 always 0) |
| det_time_o | output | 4 | Register 1 |
| func_sel_o | output | 4 | Register 2 |
| rx_gain_o | output | 4 | Register 3 |
| tx_atten_o | output | 4 | Register 4 |
| tone_sel_o | output | 4 | Register 5 |

## Verification
The assertions assume the following about the inputs:

- Each serial-clock level lasts longer than the synchroniser delay, so every edge is seen exactly once.
- `sdi_i` is stable around each rising edge.
- `rx_digit_i` does not change during a read frame.

The bench keeps to these assumptions. It holds each serial half-period for six system clocks and changes data and enable only while the serial clock is low. It changes the digit input only between frames, while the enable is high. Within those limits, the random part of the bench varies the direction, the address, the write data and the idle noise on the serial clock.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 3;
  localparam int N_STORED = 6;
  localparam int FRAME_BITS = 2 * NIB_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int RO_ADDR = 6;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam nib_t RST_VAL [N_STORED] = '{4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF};
  localparam nib_t BIT_MASK [N_STORED] = '{4'hE, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF};
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{INIT}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sclk_i,
  input  logic                sdi_i,
  input  nib_t                rd_data_i,
  output addr_t               addr_o,
  output logic                wr_en_o,
  output nib_t                wr_data_o,
  output logic                is_rd_o,
  output logic [CNT_W-1:0]    bit_cnt_o,
  output logic                sdo_o,
  output logic                sdo_oe_o
);
  localparam int HDR_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);

  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  nib_t              dat_q;
  nib_t              tx_q;
  logic              sdo_q, oe_q;
  logic              in_data;

  assign rise    = sclk_i & ~sclk_q;
  assign fall    = ~sclk_i & sclk_q;
  assign in_data = (cnt_q >= CNT_HDR) && (cnt_q < CNT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hdr_q <= '0;
      dat_q <= '0;
      tx_q  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (rise && cnt_q != CNT_END) begin
        if (cnt_q < CNT_HDR)  hdr_q <= {hdr_q[HDR_W-2:0], sdi_i};
        else if (!hdr_q[HDR_W-1]) dat_q <= {dat_q[NIB_W-2:0], sdi_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (fall && hdr_q[HDR_W-1] && in_data) begin
        if (cnt_q == CNT_HDR) begin
          sdo_q <= rd_data_i[NIB_W-1];
          tx_q  <= {rd_data_i[NIB_W-2:0], 1'b0};
        end else begin
          sdo_q <= tx_q[NIB_W-1];
          tx_q  <= {tx_q[NIB_W-2:0], 1'b0};
        end
        oe_q <= 1'b1;
      end else if (fall && cnt_q == CNT_END) begin
        oe_q  <= 1'b0;
        sdo_q <= 1'b0;
      end
    end
  end

  // commit only on the last data bit so an aborted write is lost
  assign wr_en_o   = en_i & rise & (cnt_q == CNT_LAST) & ~hdr_q[HDR_W-1];
  assign wr_data_o = {dat_q[NIB_W-2:0], sdi_i};
  assign addr_o    = hdr_q[ADDR_W-1:0];
  assign is_rd_o   = hdr_q[HDR_W-1];
  assign bit_cnt_o = cnt_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  addr_t addr_i,
  input  nib_t  wr_data_i,
  input  nib_t  ro_i,
  output nib_t  rd_data_o,
  output nib_t  regs_o [N_STORED]
);
  nib_t regs_q [N_STORED];

  for (genvar g = 0; g < N_STORED; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= RST_VAL[g];
      else if (wr_en_i && addr_i == addr_t'(g))
        regs_q[g] <= wr_data_i & BIT_MASK[g];
    end
    assign regs_o[g] = regs_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(addr_i) < N_STORED) rd_data_o = regs_q[addr_i];
    else if (int'(addr_i) == RO_ADDR) rd_data_o = ro_i;
  end
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sen_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  input  logic [3:0] rx_digit_i,
  output logic [3:0] line_mode_o,
  output logic [3:0] det_time_o,
  output logic [3:0] func_sel_o,
  output logic [3:0] rx_gain_o,
  output logic [3:0] tx_atten_o,
  output logic [3:0] tone_sel_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_INIT = 3'b100;

  logic [NPIN-1:0]  pin_raw, pin_s;
  logic             en_s;
  addr_t            addr;
  logic             wr_en, is_rd;
  nib_t             wr_data, rd_data;
  logic [CNT_W-1:0] bit_cnt;
  nib_t             regs [N_STORED];

  assign pin_raw = {sen_ni, sclk_i, sdi_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    sctl_sync #(.STAGES(SYNC_STAGES), .INIT(PIN_INIT[p])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[p]),
      .q_o   (pin_s[p])
    );
  end

  assign en_s = ~pin_s[2];

  sctl_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_s),
    .sclk_i   (pin_s[1]),
    .sdi_i    (pin_s[0]),
    .rd_data_i(rd_data),
    .addr_o   (addr),
    .wr_en_o  (wr_en),
    .wr_data_o(wr_data),
    .is_rd_o  (is_rd),
    .bit_cnt_o(bit_cnt),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  sctl_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wr_data_i(wr_data),
    .ro_i     (rx_digit_i),
    .rd_data_o(rd_data),
    .regs_o   (regs)
  );

  assign line_mode_o = regs[0];
  assign det_time_o  = regs[1];
  assign func_sel_o  = regs[2];
  assign rx_gain_o   = regs[3];
  assign tx_atten_o  = regs[4];
  assign tone_sel_o  = regs[5];
endmodule

// File: rtl/sctl_regs_chk.sv
module sctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en,
  input logic        sdo_oe,
  input logic        is_rd,
  input logic [3:0]  bit_cnt,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [23:0] reg_bus
);
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 4'd8);  // R1

  AST_WR_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (bit_cnt == 4'd7) && en);  // R2

  AST_OE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe) |-> bit_cnt == 4'd4);  // R3

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe |-> is_rd && bit_cnt >= 4'd4);  // R4

  AST_ABORT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !sdo_oe);  // R5

  AST_HIGH_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && wr_addr >= 3'd6 |=> $stable(reg_bus));  // R7
endmodule

bind sctl_regs sctl_regs_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en     (en_s),
  .sdo_oe (sdo_oe_o),
  .is_rd  (is_rd),
  .bit_cnt(bit_cnt),
  .wr_en  (wr_en),
  .wr_addr(addr),
  .reg_bus({tone_sel_o, tx_atten_o, rx_gain_o, func_sel_o, det_time_o, line_mode_o})
);

// File: tb/tb_sctl_regs.sv
module tb_sctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int N_RAND = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [3:0] rx_digit = 4'h9;
  logic [3:0] line_mode, det_time, func_sel, rx_gain, tx_atten, tone_sel;

  int total = 0;
  int bad = 0;
  logic [3:0] mdl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  sctl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .sen_ni(sen_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_digit_i(rx_digit),
    .line_mode_o(line_mode), .det_time_o(det_time), .func_sel_o(func_sel),
    .rx_gain_o(rx_gain), .tx_atten_o(tx_atten), .tone_sel_o(tone_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_read(input logic [2:0] a);
    if (a == 3'd6) return rx_digit;
    if (a == 3'd7) return 4'h0;
    return mdl[a];
  endfunction

  function automatic logic [23:0] exp_bus();
    return {mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  function automatic logic [23:0] act_bus();
    return {tone_sel, tx_atten, rx_gain, func_sel, det_time, line_mode};
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [3:0] d);
    if (a == 3'd0) mdl[0] = d & 4'hE;
    else if (a < 3'd6) mdl[a] = d;
  endtask

  task automatic xfer(input bit rw, input logic [2:0] a, input logic [3:0] wd,
                      input int nbits, output logic [3:0] rd);
    logic [7:0] bits;
    bit oe_bad, oe_miss;
    bits = {rw, a, wd};
    oe_bad = 0; oe_miss = 0; rd = '0;
    @(negedge clk); sen_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (rw && i >= 4) ? 1'($urandom) : bits[7-i];
      repeat (HALF) @(negedge clk);
      if (rw && i >= 4) begin
        if (!sdo_oe) oe_miss = 1;
        rd[7-i] = sdo;
      end else if (sdo_oe) oe_bad = 1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (nbits == 8 && sdo_oe) oe_bad = 1;
    chk(!oe_bad, "R4 oe low outside read data", 24'(oe_bad), 24'd0);
    if (rw && nbits > 4) chk(!oe_miss, "R3 oe high during read data", 24'(oe_miss), 24'd0);
    sen_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk(!sdo_oe, "R5 oe low after enable released", 24'(sdo_oe), 24'd0);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom);
      sclk = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] rd;
    void'($urandom(32'd4711));
    mdl[0] = 4'h2; mdl[1] = 4'h0; mdl[2] = 4'h0; mdl[3] = 4'h0;
    mdl[4] = 4'h0; mdl[5] = 4'hF; mdl[6] = 4'h0; mdl[7] = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(act_bus() == exp_bus(), "R8 reset exports", act_bus(), exp_bus());
    chk(!sdo_oe, "R4 oe low after reset", 24'(sdo_oe), 24'd0);
    for (int a = 0; a < 8; a++) begin
      xfer(1'b1, 3'(a), 4'h0, 8, rd);
      chk(rd == exp_read(3'(a)), "R8 R7 R10 reset readback", 24'(rd), 24'(exp_read(3'(a))));
    end

    // R9: bit 0 of address 0 stays clear
    xfer(1'b0, 3'd0, 4'hF, 8, rd); model_write(3'd0, 4'hF);
    xfer(1'b1, 3'd0, 4'h0, 8, rd);
    chk(rd == 4'hE, "R9 addr0 bit0 read", 24'(rd), 24'hE);
    chk(line_mode == 4'hE, "R9 addr0 bit0 export", 24'(line_mode), 24'hE);

    // R10: unmapped address
    xfer(1'b0, 3'd7, 4'hA, 8, rd);
    chk(act_bus() == exp_bus(), "R10 write to addr7 no effect", act_bus(), exp_bus());
    xfer(1'b1, 3'd7, 4'h0, 8, rd);
    chk(rd == 4'h0, "R10 addr7 reads zero", 24'(rd), 24'h0);

    // R7: read-only address
    rx_digit = 4'h5;
    xfer(1'b0, 3'd6, 4'hC, 8, rd);
    chk(act_bus() == exp_bus(), "R7 write to addr6 no effect", act_bus(), exp_bus());
    xfer(1'b1, 3'd6, 4'h0, 8, rd);
    chk(rd == 4'h5, "R7 addr6 returns digit", 24'(rd), 24'h5);

    // R2: MSB-first data order
    xfer(1'b0, 3'd4, 4'b1000, 8, rd); model_write(3'd4, 4'b1000);
    chk(tx_atten == 4'b1000, "R2 MSB first", 24'(tx_atten), 24'h8);

    // R5: aborted write leaves register unchanged
    xfer(1'b0, 3'd2, 4'h7, 7, rd);
    chk(func_sel == mdl[2], "R5 aborted write", 24'(func_sel), 24'(mdl[2]));
    // R5: aborted read drops driver
    xfer(1'b1, 3'd5, 4'h0, 6, rd);

    // R6: clock noise with enable high
    noise(5);
    chk(act_bus() == exp_bus(), "R6 noise no effect", act_bus(), exp_bus());
    xfer(1'b1, 3'd5, 4'h0, 8, rd);
    chk(rd == mdl[5], "R6 framing intact after noise", 24'(rd), 24'(mdl[5]));

    // R1 R2 R3 R11: random traffic
    for (int n = 0; n < N_RAND; n++) begin
      bit rw;
      logic [2:0] a;
      logic [3:0] d;
      rw = 1'($urandom);
      a  = 3'($urandom);
      d  = 4'($urandom);
      rx_digit = 4'($urandom);
      if ($urandom % 8 == 0) noise(1 + $urandom % 3);
      xfer(rw, a, d, 8, rd);
      if (rw) chk(rd == exp_read(a), "R1 R3 random read", 24'(rd), 24'(exp_read(a)));
      else model_write(a, d);
      chk(act_bus() == exp_bus(), "R11 exports follow registers", act_bus(), exp_bus());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule